// File: doc/BRIEF.md
# FIFO Slice Array Interlock Controller

This block is the control section that lets several FIFO slices placed side by side in one row work as a single wider FIFO. No external gating of their status flags is needed. Each slice carries one copy. One slice in the row is the row master. Every other slice is a slave. A slave takes its upstream enable from the slice of next-higher priority, so the input-register initialisation and the output-valid flag both ripple along the row in a fixed order. The last slave in the row is therefore the last to signal, and its flags alone tell the system when the whole row has finished an operation.

A slice decides its role once, from the level on its upstream-enable input while reset is held. Every slice drives its acknowledge output HIGH during reset. Because of this, only a slice whose upstream enable is tied LOW sees LOW at that time and becomes master. After reset, a transfer-to-stack request arms a pending initialisation. A master performs it on the next edge. A slave waits until its upstream neighbour has acknowledged. An output request (serial or parallel) issues one load pulse to the datapath. After that, the master raises output-valid directly, while a slave waits for the valid flag of its upstream neighbour. The datapath is outside this block. Everything runs on one clock, and each ripple stage takes one cycle.

Top module: `fifo_interlock_ctrl`

## Requirements
- R1: While rst_ni is LOW, init_ack_no is HIGH and out_valid_o, init_o and load_o are LOW.
- R2: The slice is master if up_en_ni is LOW at the clock edges during reset and at the first edge after release. Otherwise it is a slave. A slice that becomes a slave because up_en_ni was HIGH does not initialise until up_en_ni goes LOW.
- R3: In a master, stack_req_ni sampled LOW while idle arms a pending initialisation at that edge. At the next edge init_o pulses HIGH for exactly one cycle and init_ack_no falls at the same edge.
- R4: A slave with a pending initialisation pulses init_o, and drops init_ack_no, at the first edge at which it samples up_en_ni LOW.
- R5: After an initialisation, init_ack_no stays LOW and no further init_o occurs until stack_req_ni is sampled HIGH. init_ack_no returns HIGH at that edge.
- R6: A pending initialisation is not cancelled if stack_req_ni returns HIGH before it is performed.
- R7: An output request is present when par_req_i is HIGH or ser_req_ni is LOW. An idle slice that samples a request pulses load_o for one cycle at that edge, and it issues no further load while that request stays present.
- R8: After the load, a master raises out_valid_o at the next edge. A slave raises it at the first edge at which it samples up_oen_i HIGH while the request is still present.
- R9: out_valid_o falls at the first edge at which no request is present. A request withdrawn before out_valid_o rises leaves it LOW.
- R10: In a row of three slices chained acknowledge-to-enable and valid-to-output-enable, init_o and the rise of out_valid_o occur in priority order, one cycle apart, and the last slave is the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active LOW |
| up_en_ni | input | 1 | Upstream input enable, active LOW; tie LOW on the row master |
| stack_req_ni | input | 1 | Transfer-to-stack request, active LOW |
| par_req_i | input | 1 | Parallel output request |
| ser_req_ni | input | 1 | Serial output request, active LOW |
| up_oen_i | input | 1 | Upstream output enable (upstream slice's valid flag) |
| init_ack_no | output | 1 | LOW once this slice has initialised for the current request; feeds the next slice's up_en_ni |
| out_valid_o | output | 1 | Output register holds valid data |
| init_o | output | 1 | One-cycle input-register initialise pulse to the datapath |
| load_o | output | 1 | One-cycle load-from-stack pulse to the datapath |

## Verification
The assertions assume that rst_ni is held LOW across at least one clock edge, so the role is captured before any request is handled. They also assume up_en_ni is stable across the release of reset. Slave properties rely on up_en_ni and up_oen_i being the registered flags of the upstream slice, so they change only at clock edges. The bench drives every input at the falling clock edge. It holds the master's enable steady around each reset and connects the slaves only to real upstream slices.

// File: rtl/fil_pkg.sv
package fil_pkg;
  typedef enum logic [1:0] {
    IN_IDLE = 2'd0,
    IN_PEND = 2'd1,
    IN_DONE = 2'd2
  } in_state_e;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_WAIT  = 2'd1,
    OUT_VALID = 2'd2
  } out_state_e;
endpackage

// File: rtl/fil_role_latch.sv
module fil_role_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_en_ni,
  output logic master_o
);
  logic arm_q;
  logic master_q;

  // arm stays set through reset and the first edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b1;
    else         arm_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (arm_q) master_q <= ~up_en_ni;
  end

  assign master_o = master_q;
endmodule

// File: rtl/fil_in_ctrl.sv
module fil_in_ctrl
  import fil_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic up_en_ni,
  input  logic stack_req_ni,
  output logic init_o,
  output logic init_ack_no
);
  in_state_e state_q, state_d;
  logic init_q, init_d;

  always_comb begin
    state_d = state_q;
    init_d  = 1'b0;
    unique case (state_q)
      IN_IDLE: if (!stack_req_ni) state_d = IN_PEND;
      IN_PEND: if (master_i || !up_en_ni) begin
        state_d = IN_DONE;
        init_d  = 1'b1;
      end
      IN_DONE: if (stack_req_ni) state_d = IN_IDLE;
      default: state_d = IN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IN_IDLE;
      init_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      init_q  <= init_d;
    end
  end

  assign init_o      = init_q;
  assign init_ack_no = (state_q != IN_DONE);
endmodule

// File: rtl/fil_out_ctrl.sv
module fil_out_ctrl
  import fil_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic par_req_i,
  input  logic ser_req_ni,
  input  logic up_oen_i,
  output logic load_o,
  output logic out_valid_o
);
  out_state_e state_q, state_d;
  logic load_q, load_d;
  logic req_act;

  assign req_act = par_req_i | ~ser_req_ni;

  always_comb begin
    state_d = state_q;
    load_d  = 1'b0;
    unique case (state_q)
      OUT_IDLE: if (req_act) begin
        state_d = OUT_WAIT;
        load_d  = 1'b1;
      end
      OUT_WAIT: begin
        if (!req_act)                  state_d = OUT_IDLE;
        else if (master_i || up_oen_i) state_d = OUT_VALID;
      end
      OUT_VALID: if (!req_act) state_d = OUT_IDLE;
      default: state_d = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OUT_IDLE;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= load_d;
    end
  end

  assign load_o      = load_q;
  assign out_valid_o = (state_q == OUT_VALID);
endmodule

// File: rtl/fifo_interlock_ctrl.sv
module fifo_interlock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_en_ni,
  input  logic stack_req_ni,
  input  logic par_req_i,
  input  logic ser_req_ni,
  input  logic up_oen_i,
  output logic init_ack_no,
  output logic out_valid_o,
  output logic init_o,
  output logic load_o
);
  logic is_master;

  fil_role_latch u_role (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .up_en_ni (up_en_ni),
    .master_o (is_master)
  );

  fil_in_ctrl u_in (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .master_i     (is_master),
    .up_en_ni     (up_en_ni),
    .stack_req_ni (stack_req_ni),
    .init_o       (init_o),
    .init_ack_no  (init_ack_no)
  );

  fil_out_ctrl u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_i    (is_master),
    .par_req_i   (par_req_i),
    .ser_req_ni  (ser_req_ni),
    .up_oen_i    (up_oen_i),
    .load_o      (load_o),
    .out_valid_o (out_valid_o)
  );
endmodule

// File: rtl/fifo_interlock_chk.sv
module fifo_interlock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic up_en_ni,
  input logic stack_req_ni,
  input logic par_req_i,
  input logic ser_req_ni,
  input logic up_oen_i,
  input logic master_i,
  input logic init_ack_no,
  input logic out_valid_o,
  input logic init_o,
  input logic load_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_flags_R1: assert (init_ack_no && !out_valid_o && !init_o && !load_o);
    end
  end

  assert_init_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> !init_o);

  assert_ack_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_ack_no) |-> init_o);

  assert_slave_init_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_o && !master_i) |-> $past(!up_en_ni));

  assert_ack_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_ack_no && !stack_req_ni) |=> (!init_ack_no && !init_o));

  assert_load_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  assert_slave_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_valid_o) && !master_i) |-> $past(up_oen_i));

  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_req_i && ser_req_ni) |=> !out_valid_o);
endmodule

bind fifo_interlock_ctrl fifo_interlock_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .up_en_ni     (up_en_ni),
  .stack_req_ni (stack_req_ni),
  .par_req_i    (par_req_i),
  .ser_req_ni   (ser_req_ni),
  .up_oen_i     (up_oen_i),
  .master_i     (is_master),
  .init_ack_no  (init_ack_no),
  .out_valid_o  (out_valid_o),
  .init_o       (init_o),
  .load_o       (load_o)
);

// File: tb/tb_fifo_interlock_ctrl.sv
`timescale 1ns/1ps
module tb_fifo_interlock_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic m_en_n = 1'b0;
  logic tts_n = 1'b1;
  logic par = 1'b0;
  logic ser_n = 1'b1;
  logic [2:0] ack_n, vld, ini, ld;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int first_ini [3];
  int first_vld [3];

  always #2.5 clk = ~clk;

  fifo_interlock_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .up_en_ni(m_en_n), .stack_req_ni(tts_n),
    .par_req_i(par), .ser_req_ni(ser_n), .up_oen_i(1'b0),
    .init_ack_no(ack_n[0]), .out_valid_o(vld[0]), .init_o(ini[0]), .load_o(ld[0]));
  fifo_interlock_ctrl dut_s1 (
    .clk_i(clk), .rst_ni(rst_n), .up_en_ni(ack_n[0]), .stack_req_ni(tts_n),
    .par_req_i(par), .ser_req_ni(ser_n), .up_oen_i(vld[0]),
    .init_ack_no(ack_n[1]), .out_valid_o(vld[1]), .init_o(ini[1]), .load_o(ld[1]));
  fifo_interlock_ctrl dut_s2 (
    .clk_i(clk), .rst_ni(rst_n), .up_en_ni(ack_n[1]), .stack_req_ni(tts_n),
    .par_req_i(par), .ser_req_ni(ser_n), .up_oen_i(vld[1]),
    .init_ack_no(ack_n[2]), .out_valid_o(vld[2]), .init_o(ini[2]), .load_o(ld[2]));

  // reference model built from the requirements
  int  m_ist [3];
  int  m_ost [3];
  bit  m_ini [3];
  bit  m_ld  [3];
  bit  m_mst [3];
  bit  m_arm = 1'b1;

  function automatic bit exp_ack(int i);
    return !(m_ist[i] == 2);
  endfunction
  function automatic bit exp_vld(int i);
    return (m_ost[i] == 2);
  endfunction

  always @(posedge clk) begin
    int  pi [3];
    int  po [3];
    bit  en_n, oen, req;
    for (int i = 0; i < 3; i++) begin pi[i] = m_ist[i]; po[i] = m_ost[i]; end
    req = par || !ser_n;
    for (int i = 0; i < 3; i++) begin
      en_n = (i == 0) ? m_en_n : !(pi[i-1] == 2);
      oen  = (i == 0) ? 1'b0   : (po[i-1] == 2);
      if (m_arm) m_mst[i] = !en_n;
      m_ini[i] = 1'b0;
      m_ld[i]  = 1'b0;
      if (!rst_n) begin
        m_ist[i] = 0;
        m_ost[i] = 0;
      end else begin
        case (pi[i])
          0: if (!tts_n) m_ist[i] = 1;
          1: if (m_mst[i] || !en_n) begin m_ist[i] = 2; m_ini[i] = 1'b1; end
          default: if (tts_n) m_ist[i] = 0;
        endcase
        case (po[i])
          0: if (req) begin m_ost[i] = 1; m_ld[i] = 1'b1; end
          1: if (!req) m_ost[i] = 0; else if (m_mst[i] || oen) m_ost[i] = 2;
          default: if (!req) m_ost[i] = 0;
        endcase
      end
    end
    m_arm = !rst_n;
  end

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < 3; i++) begin
      if (!rst_n) begin
        chk(ack_n[i], 1'b1, "R1", $sformatf("ack slice %0d", i));
        chk(vld[i],   1'b0, "R1", $sformatf("valid slice %0d", i));
        chk(ini[i],   1'b0, "R1", $sformatf("init slice %0d", i));
        chk(ld[i],    1'b0, "R1", $sformatf("load slice %0d", i));
      end else begin
        chk(ini[i],   m_ini[i],   (i == 0) ? "R3" : "R4", $sformatf("init slice %0d", i));
        chk(ack_n[i], exp_ack(i), "R5", $sformatf("ack slice %0d", i));
        chk(ld[i],    m_ld[i],    "R7", $sformatf("load slice %0d", i));
        chk(vld[i],   exp_vld(i), "R8", $sformatf("valid slice %0d", i));
      end
      if (ini[i] && first_ini[i] < 0) first_ini[i] = cyc;
      if (vld[i] && first_vld[i] < 0) first_vld[i] = cyc;
    end
  endtask

  task automatic clear_marks();
    for (int i = 0; i < 3; i++) begin first_ini[i] = -1; first_vld[i] = -1; end
  endtask

  task automatic do_reset(input bit en_n);
    m_en_n = en_n; tts_n = 1'b1; par = 1'b0; ser_n = 1'b1;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (2) step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_marks();
    @(negedge clk);
    do_reset(1'b0);

    // R10: chained init and valid order
    clear_marks();
    tts_n = 1'b0; par = 1'b1;
    repeat (8) step();
    checks++;
    if (!(first_ini[0] > 0 && first_ini[1] == first_ini[0] + 1 && first_ini[2] == first_ini[1] + 1)) begin
      fails++;
      $display("FAIL R10 init order: actual %0d,%0d,%0d expected consecutive", first_ini[0], first_ini[1], first_ini[2]);
    end
    checks++;
    if (!(first_vld[0] > 0 && first_vld[1] == first_vld[0] + 1 && first_vld[2] == first_vld[1] + 1)) begin
      fails++;
      $display("FAIL R10 valid order: actual %0d,%0d,%0d expected consecutive", first_vld[0], first_vld[1], first_vld[2]);
    end
    // R5 and R9: release
    tts_n = 1'b1; par = 1'b0;
    step();
    chk(ack_n[2], 1'b1, "R5", "last ack after release");
    chk(vld[2],   1'b0, "R9", "last valid after release");
    repeat (2) step();

    // R6: single-cycle stack request still initialises every slice
    clear_marks();
    tts_n = 1'b0; step(); tts_n = 1'b1;
    repeat (6) step();
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (first_ini[i] < 0) begin
        fails++;
        $display("FAIL R6 slice %0d init: actual none expected one", i);
      end
    end

    // R9: request withdrawn before valid; serial request
    clear_marks();
    ser_n = 1'b0; step(); ser_n = 1'b1;
    repeat (5) step();
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (first_vld[i] >= 0) begin
        fails++;
        $display("FAIL R9 slice %0d valid: actual rose expected low", i);
      end
    end

    // R2: master enable held HIGH in reset -> no slice acts
    do_reset(1'b1);
    clear_marks();
    tts_n = 1'b0; par = 1'b1;
    repeat (6) step();
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (first_ini[i] >= 0) begin
        fails++;
        $display("FAIL R2 slice %0d init: actual pulse expected none", i);
      end
    end
    m_en_n = 1'b0;
    repeat (5) step();
    chk(ack_n[2], 1'b0, "R2", "last ack after upstream enable");
    tts_n = 1'b1; par = 1'b0;
    step();

    // random phase with a proper row master
    do_reset(1'b0);
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 5) == 0) tts_n = ~tts_n;
      if ($urandom_range(0, 4) == 0) par   = ~par;
      if ($urandom_range(0, 6) == 0) ser_n = ~ser_n;
      step();
    end
    tts_n = 1'b1; par = 1'b0; ser_n = 1'b1;
    repeat (3) step();
    summary();
  end
endmodule